// File: doc/BRIEF.md
# Shared-Memory Ring Drain Engine

This block is a memory-bus master that empties a single-producer, single-consumer circular queue held in shared memory. It streams each queued word out on a valid/ready interface. The queue region starts at a base byte address. Its first header word holds the consumer's head index, which this engine owns. Its second header word holds the producer's tail index. Slot data follows a four-word header, with one 32-bit word per slot. The producer and the engine coordinate only through these memory words.

After a start pulse the engine delivers a programmed number of words. It reads the remote tail to find out whether data is waiting. While the ring is empty it backs off for a programmed interval before polling again. Each word is fetched from the slot at the current head and presented downstream. Only after the word has been taken does the engine publish the advanced head, which frees the slot for the producer. A locally held copy of the tail serves several pops before memory is asked again.

Top module: `ring_drain_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it, `mem_req_valid`, `out_valid` and `done` are all low; a start after reset begins with head and cached tail at zero.
- R2: Tail reads use address base+4 and head writes use address base+0. Slot reads use address base+16+4·head, where head is the index last written to memory.
- R3: When a tail read returns the current head (ring empty), the next tail read request appears exactly P+2 cycles after the response cycle, where P is `cfg_poll`.
- R4: While the cached tail differs from head, slots are read without re-reading tail. A ring prefilled with N ≤ C−1 words, drained with count N, costs exactly one tail read.
- R5: Words leave on `out_data` in the order the producer enqueued them, with none lost or repeated, and exactly `cfg_count` of them in total.
- R6: Once raised, `out_valid` stays high and `out_data` stays unchanged until `out_ready` is seen.
- R7: After each output handshake the engine writes (head+1) mod C as the new head, with C being `cfg_slots`. Every such write follows an accepted output word, and there is one write per word.
- R8: `done` is a one-cycle pulse. It is seen two cycles after the final head-write handshake, or two cycles after a start with a count of zero, which also issues no bus request.
- R9: A bus request holds its valid, address, write flag and write data steady until `mem_req_ready` is high.
- R10: At most one read is outstanding: no request is raised between a read's acceptance and its `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a drain run (sampled while idle) |
| cfg_base | input | AW | Byte address of the queue header |
| cfg_slots | input | DW | Ring capacity C in slots |
| cfg_count | input | CW | Number of words to deliver |
| cfg_poll | input | TW | Backoff cycles P after an empty poll |
| mem_req_valid | output | 1 | Bus request valid |
| mem_req_ready | input | 1 | Bus request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request byte address |
| mem_req_wdata | output | DW | Write data (new head) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | DW | Dequeued word |
| done | output | 1 | Programmed count delivered |

## Verification
Every handshake is registered once inside the engine, so the bench drives inputs and samples outputs on the falling edge and counts in those half-cycle-offset steps. A bus acceptance or read response seen at one falling edge takes effect at the next rising edge. The backoff is measured from the empty response to the next tail request and is due exactly P+2 steps later. `done` is due exactly two steps after the last head-write acceptance, or after start when the count is zero. Data, address and head values are checked at the step of each handshake against a memory and producer model kept in the bench.

// File: rtl/ring_drain_pkg.sv
package ring_drain_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_TAIL_REQ,
        ST_TAIL_WAIT,
        ST_BACKOFF,
        ST_SLOT_REQ,
        ST_SLOT_WAIT,
        ST_PRESENT,
        ST_HEAD_REQ
    } drain_state_e;

    typedef enum logic [1:0] {
        AD_HEAD,
        AD_TAIL,
        AD_SLOT
    } addr_sel_e;

endpackage

// File: rtl/ring_ptr_wrap.sv
module ring_ptr_wrap #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] slots,
    output logic [PW-1:0] nxt
);
    logic [PW:0] inc;

    always_comb begin
        inc = {1'b0, ptr} + {{PW{1'b0}}, 1'b1};
        nxt = (inc >= {1'b0, slots}) ? '0 : inc[PW-1:0];
    end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_drain_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int HDR_WORDS = 4
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] head,
    input  addr_sel_e     sel,
    output logic [AW-1:0] addr
);
    localparam int BYTES = DW / 8;
    localparam int SHIFT = $clog2(BYTES);

    logic [AW-1:0] slot_words;

    always_comb begin
        slot_words = AW'(HDR_WORDS) + AW'(head);
        unique case (sel)
            AD_TAIL: addr = base + (AW'(1) << SHIFT);
            AD_SLOT: addr = base + (slot_words << SHIFT);
            default: addr = base;
        endcase
    end
endmodule

// File: rtl/ring_poll_timer.sv
module ring_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ring_drain_engine.sv
module ring_drain_engine
    import ring_drain_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int TW        = 16,
    parameter int HDR_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_base,
    input  logic [DW-1:0] cfg_slots,
    input  logic [CW-1:0] cfg_count,
    input  logic [TW-1:0] cfg_poll,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          done
);
    typedef struct packed {
        drain_state_e  st;
        logic [AW-1:0] base;
        logic [DW-1:0] slots;
        logic [DW-1:0] head;
        logic [DW-1:0] tail;
        logic [CW-1:0] left;
        logic [TW-1:0] poll;
        logic [DW-1:0] word;
        logic          done;
    } regs_t;

    regs_t     r_d, r_q;
    logic      timer_load;
    logic      timer_expired;
    logic [DW-1:0] head_nxt;
    addr_sel_e sel;

    ring_ptr_wrap #(.PW(DW)) u_wrap (
        .ptr   (r_q.head),
        .slots (r_q.slots),
        .nxt   (head_nxt)
    );

    ring_addr_gen #(.AW(AW), .DW(DW), .HDR_WORDS(HDR_WORDS)) u_addr (
        .base (r_q.base),
        .head (r_q.head),
        .sel  (sel),
        .addr (mem_req_addr)
    );

    ring_poll_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (r_q.poll),
        .expired  (timer_expired)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        timer_load = 1'b0;
        sel        = AD_HEAD;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base  = cfg_base;
                    r_d.slots = cfg_slots;
                    r_d.left  = cfg_count;
                    r_d.poll  = cfg_poll;
                    r_d.head  = '0;
                    r_d.tail  = '0;
                    r_d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (r_q.left == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (r_q.head != r_q.tail) begin
                    r_d.st = ST_SLOT_REQ;
                end else begin
                    r_d.st = ST_TAIL_REQ;
                end
            end
            ST_TAIL_REQ: begin
                sel = AD_TAIL;
                if (mem_req_ready) r_d.st = ST_TAIL_WAIT;
            end
            ST_TAIL_WAIT: begin
                sel = AD_TAIL;
                if (mem_rsp_valid) begin
                    r_d.tail = mem_rsp_data;
                    if (mem_rsp_data == r_q.head) begin
                        timer_load = 1'b1;
                        r_d.st     = ST_BACKOFF;
                    end else begin
                        r_d.st = ST_SLOT_REQ;
                    end
                end
            end
            ST_BACKOFF: begin
                if (timer_expired) r_d.st = ST_TAIL_REQ;
            end
            ST_SLOT_REQ: begin
                sel = AD_SLOT;
                if (mem_req_ready) r_d.st = ST_SLOT_WAIT;
            end
            ST_SLOT_WAIT: begin
                sel = AD_SLOT;
                if (mem_rsp_valid) begin
                    r_d.word = mem_rsp_data;
                    r_d.st   = ST_PRESENT;
                end
            end
            ST_PRESENT: begin
                if (out_ready) r_d.st = ST_HEAD_REQ;
            end
            ST_HEAD_REQ: begin
                sel = AD_HEAD;
                if (mem_req_ready) begin
                    r_d.head = head_nxt;
                    r_d.left = r_q.left - CW'(1);
                    r_d.st   = ST_CHECK;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_valid = (r_q.st == ST_TAIL_REQ) || (r_q.st == ST_SLOT_REQ) ||
                           (r_q.st == ST_HEAD_REQ);
    assign mem_req_write = (r_q.st == ST_HEAD_REQ);
    assign mem_req_wdata = (r_q.st == ST_HEAD_REQ) ? head_nxt : '0;
    assign out_valid     = (r_q.st == ST_PRESENT);
    assign out_data      = r_q.word;
    assign done          = r_q.done;
endmodule

module ring_drain_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_write,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_wdata,
    input logic          mem_rsp_valid,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          done
);
    logic rd_pend_q;
    logic pop_credit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q    <= 1'b0;
            pop_credit_q <= 1'b0;
        end else begin
            if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend_q <= 1'b1;
            else if (mem_rsp_valid) rd_pend_q <= 1'b0;
            if (out_valid && out_ready) pop_credit_q <= 1'b1;
            else if (mem_req_valid && mem_req_ready && mem_req_write) pop_credit_q <= 1'b0;
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
        $stable(mem_req_write) && $stable(mem_req_wdata));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pend_q |-> !mem_req_valid);

    // R7
    head_after_pop_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> pop_credit_q);
endmodule

bind ring_drain_engine ring_drain_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .done          (done)
);

// File: tb/ring_drain_engine_test.sv
`timescale 1ns/1ps
module ring_drain_engine_test;
    localparam int AW = 32, DW = 32, CW = 16, TW = 16;
    localparam logic [AW-1:0] BASE = 32'h0000_0100;
    // cap, count, poll, prefill, producer gap, flags(b0 out stall, b1 bus stall), expected tail reads
    localparam logic [47:0] SCEN [0:4] = '{
        48'h08_07_03_07_00_0_1,
        48'h04_0A_02_00_05_1_0,
        48'h08_14_00_00_01_3_0,
        48'h02_05_06_00_14_0_0,
        48'h10_0C_01_0C_00_2_1
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [DW-1:0] cfg_slots = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [TW-1:0] cfg_poll = '0;
    logic mem_req_valid, mem_req_write, out_valid, done;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, out_data;
    logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0, out_ready = 1'b1;
    logic [DW-1:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    ring_drain_engine #(.AW(AW), .DW(DW), .CW(CW), .TW(TW)) uut (
        .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_slots(cfg_slots),
        .cfg_count(cfg_count), .cfg_poll(cfg_poll), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int s, input int k);
        return 32'hC0DE_0000 + 32'(s * 4096) + 32'(k * 3 + 1);
    endfunction

    logic [DW-1:0] mem [32];
    int cap = 1, poll = 0, gap = 0, flags = 0, scen = 0;
    int ptail = 0, pk = 0, ptotal = 0, pcool = 0;
    bit prod_en = 0, quiet = 1;
    int cyc = 0, rx_k = 0, tail_reads = 0, writes = 0, pops = 0, reqs_seen = 0;
    int done_seen = 0, done_cyc = 0, last_wr_cyc = 0, armed_cyc = 0;
    bit rp_valid = 0, rp_tail = 0, rp_empty = 0, rd_pend = 0, poll_armed = 0, hold_pending = 0;
    logic [DW-1:0] rp_data = '0, hold_data = '0;

    always @(negedge clk) begin
        cyc++;
        if (quiet) begin
            mem_rsp_valid = 1'b0;
        end else begin
            mem_rsp_valid = rp_valid;
            mem_rsp_data  = rp_valid ? rp_data : '0;
            if (rp_valid) rd_pend = 0;
            if (rp_valid && rp_tail && rp_empty) begin
                poll_armed = 1;
                armed_cyc  = cyc;
            end
            rp_valid = 0;
            mem_req_ready = !(flags[1] && (cyc % 3 == 0));
            out_ready     = !(flags[0] && (cyc % 4 < 2));
            if (hold_pending) begin
                check(out_valid && out_data == hold_data, "R6 held word", out_data, hold_data);
                hold_pending = 0;
            end
            if (mem_req_valid) begin
                reqs_seen++;
                check(!rd_pend, "R10 request while read outstanding", 32'(rd_pend), 0);
                if (poll_armed && !mem_req_write && mem_req_addr == BASE + 4) begin
                    check(cyc - armed_cyc == poll + 2, "R3 backoff gap", 32'(cyc - armed_cyc), 32'(poll + 2));
                    poll_armed = 0;
                end
                if (mem_req_ready) begin
                    if (mem_req_write) begin
                        check(mem_req_addr == BASE, "R2 head write address", mem_req_addr, BASE);
                        check(mem_req_wdata == 32'((int'(mem[0]) + 1) % cap), "R7 head value",
                              mem_req_wdata, 32'((int'(mem[0]) + 1) % cap));
                        check(pops > writes, "R7 write before pop", 32'(writes), 32'(pops));
                        mem[0] = mem_req_wdata;
                        writes++;
                        last_wr_cyc = cyc;
                    end else begin
                        automatic int idx = int'((mem_req_addr - BASE) >> 2);
                        if (idx == 1) begin
                            tail_reads++;
                            check(1'b1, "R2 tail address", mem_req_addr, BASE + 4);
                        end else begin
                            check(mem_req_addr == BASE + 16 + 4 * mem[0], "R2 slot address",
                                  mem_req_addr, BASE + 16 + 4 * mem[0]);
                        end
                        rp_valid = 1;
                        rp_tail  = (idx == 1);
                        rp_empty = (mem[1] == mem[0]);
                        rp_data  = (idx >= 0 && idx < 32) ? mem[idx] : 32'hDEAD_BEEF;
                        rd_pend  = 1;
                    end
                end
            end
            if (out_valid) begin
                if (out_ready) begin
                    check(out_data == pat(scen, rx_k), "R5 word order", out_data, pat(scen, rx_k));
                    rx_k++;
                    pops++;
                end else begin
                    hold_pending = 1;
                    hold_data    = out_data;
                end
            end
            if (prod_en && pk < ptotal) begin
                if (pcool > 0) pcool--;
                else if ((ptail + 1) % cap != int'(mem[0])) begin
                    mem[4 + ptail] = pat(scen, pk);
                    ptail = (ptail + 1) % cap;
                    mem[1] = 32'(ptail);
                    pk++;
                    pcool = gap;
                end
            end
            if (done) begin
                done_seen++;
                done_cyc = cyc;
            end
        end
    end

    task automatic launch(input int s, input int cnt_override);
        automatic logic [47:0] v = SCEN[s];
        automatic int pre = int'(v[23:16]);
        @(posedge clk);
        scen = s; cap = int'(v[47:40]); poll = int'(v[31:24]); gap = int'(v[15:8]);
        flags = int'(v[7:4]);
        ptotal = (cnt_override >= 0) ? cnt_override : int'(v[39:32]);
        for (int i = 0; i < 32; i++) mem[i] = '0;
        mem[2] = 32'(cap);
        for (int i = 0; i < pre; i++) mem[4 + i] = pat(s, i);
        mem[1] = 32'(pre);
        ptail = pre; pk = pre; pcool = gap;
        rx_k = 0; tail_reads = 0; writes = 0; pops = 0; reqs_seen = 0; done_seen = 0;
        rp_valid = 0; rd_pend = 0; poll_armed = 0; hold_pending = 0;
        prod_en = 1; quiet = 0;
        cfg_base = BASE; cfg_slots = 32'(cap); cfg_count = CW'(ptotal); cfg_poll = TW'(poll);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic finish_scen(input int s);
        automatic logic [47:0] v = SCEN[s];
        while (done_seen == 0) @(posedge clk);
        repeat (5) @(posedge clk);
        prod_en = 0;
        check(rx_k == ptotal, "R5 word total", 32'(rx_k), 32'(ptotal));
        check(writes == ptotal, "R7 head write count", 32'(writes), 32'(ptotal));
        check(done_seen == 1, "R8 done pulses", 32'(done_seen), 1);
        check(done_cyc - last_wr_cyc == 2, "R8 done timing", 32'(done_cyc - last_wr_cyc), 2);
        if (v[3:0] != 0)
            check(tail_reads == int'(v[3:0]), "R4 tail reads", 32'(tail_reads), 32'(v[3:0]));
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!mem_req_valid && !out_valid && !done, "R1 reset outputs",
              {29'b0, mem_req_valid, out_valid, done}, 0);
        rst = 1'b0;

        for (int s = 0; s < 5; s++) begin
            launch(s, -1);
            finish_scen(s);
        end

        // R8: zero count completes without bus traffic
        launch(0, 0);
        check(!done, "R8 zero count early", 32'(done), 0);
        @(negedge clk);
        check(done, "R8 zero count done", 32'(done), 1);
        @(negedge clk);
        check(!done, "R8 zero count pulse", 32'(done), 0);
        repeat (3) @(negedge clk);
        check(reqs_seen == 0, "R8 zero count requests", 32'(reqs_seen), 0);

        // R1: reset in mid-run, then a fresh run from cleared pointers
        launch(1, -1);
        while (rx_k < 3) @(posedge clk);
        @(posedge clk) quiet = 1;
        prod_en = 0;
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!mem_req_valid && !out_valid && !done, "R1 mid-run reset",
              {29'b0, mem_req_valid, out_valid, done}, 0);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(!mem_req_valid && !out_valid && !done, "R1 idle after reset",
              {29'b0, mem_req_valid, out_valid, done}, 0);
        launch(0, -1);
        finish_scen(0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule